// File: doc/BRIEF.md
# Receiver Status-Flag Output Sequencer

This block takes the per-subframe side information produced by a biphase-mark decoder in a digital audio receiver and presents it on five registered serial pins: a channel-status bit, a user bit, a channel-status block marker, an error flag and a combined validity-or-error flag. Each decoded subframe arrives as a one-cycle load pulse. The pulse carries the channel-status, user and validity bits, a parity-error flag, a coding-violation flag, a block-start marker and the receiver lock state.

The outputs are timed against the serial clock and frame sync of the audio serial port. Both arrive as level inputs and are sampled in the system clock domain. A flag's value is held in a pending stage until its scheduled update point. In the non-I2S port formats, the channel-status bit, user bit and block marker change one serial-clock period before the active frame-sync edge, so that edge can latch them outside the block. In the I2S formats they change on that edge. Both error flags always change on the active frame-sync edge.

A subframe counter runs over a block of 384 subframes (192 frames). It drives the block marker high for the first 64 subframes of each block.

Top module: `sfo_top`

## Requirements
- R1: `cs_out` and `usr_out` carry the channel-status and user bits of the loaded subframe once its update point is reached.
- R2: `err_out` is high for a subframe whose parity-error or coding-violation flag was set, or whose lock input was low.
- R3: `verr_out` equals the subframe's validity bit OR'ed with its `err_out` value.
- R4: `err_out` and `verr_out` change only on an active frame-sync edge, in every port format. Until that edge they keep the previous subframe's values.
- R5: With `i2s_mode` = 0, `cs_out`, `usr_out` and `blk_out` change at the serial-clock rising edge that begins the last serial-clock period of the subframe. `sck_per_sub` gives the number of serial-clock periods per subframe. That edge comes one period before the next active frame-sync edge.
- R6: With `i2s_mode` = 1, `cs_out`, `usr_out` and `blk_out` change on the active frame-sync edge. The active edge is a rising edge with the default parameter.
- R7: `blk_out` is high for subframe indices 0 to 63 of a block and low for indices 64 to 383. The index wraps from 383 to 0.
- R8: A subframe whose block-start marker is set is given index 0, so `blk_out` goes high and the count restarts from there.
- R9: A subframe whose lock input is low forces `blk_out` low and clears the index. The next locked subframe without a block-start marker gets index 0.
- R10: A synchronous active-low reset clears every output and the subframe index to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock level from the audio port |
| fsync | input | 1 | Frame sync level from the audio port |
| i2s_mode | input | 1 | 1 selects I2S-style update timing |
| sck_per_sub | input | CNT_W | Serial-clock periods per subframe (at least 2) |
| sf_load | input | 1 | One-cycle pulse: a new subframe's flags are valid |
| sf_cs | input | 1 | Channel-status bit |
| sf_usr | input | 1 | User bit |
| sf_vbit | input | 1 | Validity bit |
| sf_par_err | input | 1 | Parity error |
| sf_code_err | input | 1 | Biphase coding violation |
| sf_locked | input | 1 | Receiver lock state |
| sf_blk_start | input | 1 | Subframe opens a new channel-status block |
| cs_out | output | 1 | Channel-status bit output |
| usr_out | output | 1 | User bit output |
| blk_out | output | 1 | Channel-status block marker |
| verr_out | output | 1 | Validity OR error flag |
| err_out | output | 1 | Error flag |

## Verification
The hardest point to reach from the ports is the short window between the early status update and the frame-sync edge. In that window, in the non-I2S format, `cs_out` already shows the new subframe while `err_out` must still show the old one. The bench reaches it by driving the serial clock and frame sync cycle by cycle and sampling inside the last serial-clock period of each subframe. It uses alternating bit patterns, so a change made one period early or late shows as a mismatch. The marker's wrap after 383 subframes is reached by a long run of locked subframes. The lock-loss and restart cases are placed mid-block.

// File: rtl/sfo_pkg.sv
// Shared types for the status-flag output sequencer.
package sfo_pkg;
    // Flags held for one subframe between capture and update.
    typedef struct packed {
        logic cs;      // channel-status bit
        logic usr;     // user bit
        logic vbit;    // validity bit
        logic err;     // parity | coding violation | not locked
        logic locked;  // receiver lock at capture time
        logic blk;     // block-start marker
    } sf_flags_t;
endpackage

// File: rtl/sfo_slot_timer.sv
// Slot timer: detects the active frame-sync edge and the serial-clock
// edge that begins the last serial-clock period of a subframe.
// Assumes sck and fsync are already synchronous to clk, that the
// frame-sync edge lines up with a serial-clock rising edge, and that
// sck_per_sub is at least 2.
module sfo_slot_timer #(
    parameter int CNT_W          = 8,
    parameter bit FS_RISE_ACTIVE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             fsync,
    input  logic [CNT_W-1:0] sck_per_sub,
    output logic             fs_edge,
    output logic             pre_edge
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic             FS_IDLE = ~FS_RISE_ACTIVE;

    logic             sck_q;
    logic             fs_q;
    logic             sck_rise;
    logic [CNT_W-1:0] cnt;

    // Delay the sampled port levels by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            fs_q  <= FS_IDLE;
        end else begin
            sck_q <= sck;
            fs_q  <= fsync;
        end
    end

    assign sck_rise = sck & ~sck_q;

    // The active frame-sync polarity is chosen by a parameter.
    generate
        if (FS_RISE_ACTIVE) begin : g_rise
            assign fs_edge = fsync & ~fs_q;
        end else begin : g_fall
            assign fs_edge = ~fsync & fs_q;
        end
    endgenerate

    // Count serial-clock periods since the last frame-sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (fs_edge)
            cnt <= '0;
        else if (sck_rise && cnt != CNT_MAX)
            cnt <= cnt + ONE;
    end

    // Early point: the rise that begins period sck_per_sub-1.
    assign pre_edge = sck_rise && !fs_edge && ((cnt + ONE) == (sck_per_sub - ONE));

    assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fs_edge |=> (cnt == '0));
    assert_pre_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_edge |=> (sck_q == 1'b1));
endmodule

// File: rtl/sfo_block_ctr.sv
// Channel-status block counter: tracks the subframe index inside a
// 384-subframe block and drives the block marker. It steps once per
// committed subframe, restarts on a block-start marker and is held
// clear while the committed subframe was out of lock.
module sfo_block_ctr #(
    parameter int BLOCK_SUBS = 384,
    parameter int MARK_SUBS  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic locked,
    input  logic restart,
    output logic blk_out
);
    localparam int              IDX_W = $clog2(BLOCK_SUBS);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(BLOCK_SUBS - 1);
    localparam logic [IDX_W-1:0] MARK  = IDX_W'(MARK_SUBS);
    localparam logic [IDX_W-1:0] ONE   = IDX_W'(1);

    logic [IDX_W-1:0] idx;   // index the next committed subframe gets

    // Advance the index and set the marker for the subframe being committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            blk_out <= 1'b0;
        end else if (step) begin
            if (!locked) begin
                idx     <= '0;
                blk_out <= 1'b0;
            end else if (restart) begin
                idx     <= ONE;
                blk_out <= 1'b1;
            end else begin
                idx     <= (idx == LAST) ? '0 : idx + ONE;
                blk_out <= (idx < MARK);
            end
        end
    end

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);
    assert_mark_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_out |-> (idx >= ONE && idx <= MARK));
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && locked && restart) |=> (blk_out && idx == ONE));
    assert_unlock_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !locked) |=> (!blk_out && idx == '0));
endmodule

// File: rtl/sfo_flag_stage.sv
// Flag stage: captures a subframe's flags into a pending register on
// the load pulse. It moves the status bits and the error flags to
// their output registers at separately scheduled update points.
// Assumes a load does not fall in the same cycle as an update.
module sfo_flag_stage
    import sfo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  sf_flags_t flags_in,
    input  logic      upd_status,
    input  logic      upd_err,
    output sf_flags_t pend,
    output logic      cs_out,
    output logic      usr_out,
    output logic      verr_out,
    output logic      err_out
);
    // Hold the latest subframe's flags until they are committed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (load)
            pend <= flags_in;
    end

    // Commit channel-status and user bits at the status update point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_out  <= 1'b0;
            usr_out <= 1'b0;
        end else if (upd_status) begin
            cs_out  <= pend.cs;
            usr_out <= pend.usr;
        end
    end

    // Commit error flags at the frame-sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_out  <= 1'b0;
            verr_out <= 1'b0;
        end else if (upd_err) begin
            err_out  <= pend.err;
            verr_out <= pend.err | pend.vbit;
        end
    end

    assert_err_implies_verr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> verr_out);
    assert_err_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_out) |-> $past(upd_err));
    assert_verr_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(verr_out) |-> $past(upd_err));
    assert_cs_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_out) |-> $past(upd_status));
endmodule

// File: rtl/sfo_top.sv
// Status-flag output sequencer top. It combines the error sources,
// selects the status update point from the port format, and wires the
// slot timer, flag stage and block counter together.
module sfo_top
    import sfo_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter bit FS_RISE_ACTIVE = 1'b1,
    parameter int BLOCK_SUBS     = 384,
    parameter int MARK_SUBS      = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             fsync,
    input  logic             i2s_mode,
    input  logic [CNT_W-1:0] sck_per_sub,
    input  logic             sf_load,
    input  logic             sf_cs,
    input  logic             sf_usr,
    input  logic             sf_vbit,
    input  logic             sf_par_err,
    input  logic             sf_code_err,
    input  logic             sf_locked,
    input  logic             sf_blk_start,
    output logic             cs_out,
    output logic             usr_out,
    output logic             blk_out,
    output logic             verr_out,
    output logic             err_out
);
    logic      fs_edge;
    logic      pre_edge;
    logic      upd_status;
    sf_flags_t flags_in;
    sf_flags_t pend;

    // Pack the incoming flags and fold the three error sources together.
    always_comb begin
        flags_in.cs     = sf_cs;
        flags_in.usr    = sf_usr;
        flags_in.vbit   = sf_vbit;
        flags_in.err    = sf_par_err | sf_code_err | ~sf_locked;
        flags_in.locked = sf_locked;
        flags_in.blk    = sf_blk_start;
    end

    // I2S formats update status on the edge; the others one period early.
    assign upd_status = i2s_mode ? fs_edge : pre_edge;

    sfo_slot_timer #(
        .CNT_W          (CNT_W),
        .FS_RISE_ACTIVE (FS_RISE_ACTIVE)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck         (sck),
        .fsync       (fsync),
        .sck_per_sub (sck_per_sub),
        .fs_edge     (fs_edge),
        .pre_edge    (pre_edge)
    );

    sfo_flag_stage u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sf_load),
        .flags_in   (flags_in),
        .upd_status (upd_status),
        .upd_err    (fs_edge),
        .pend       (pend),
        .cs_out     (cs_out),
        .usr_out    (usr_out),
        .verr_out   (verr_out),
        .err_out    (err_out)
    );

    sfo_block_ctr #(
        .BLOCK_SUBS (BLOCK_SUBS),
        .MARK_SUBS  (MARK_SUBS)
    ) u_block (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (upd_status),
        .locked  (pend.locked),
        .restart (pend.blk),
        .blk_out (blk_out)
    );

    assert_i2s_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cs_out) && $past(i2s_mode)) |-> $past(fs_edge));
    assert_std_before_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(blk_out) && !$past(i2s_mode)) |-> $past(pre_edge));
endmodule

// File: tb/tb_sfo_top.sv
// Self-checking bench: a vector table walked in both port formats,
// then directed runs for the block marker, restart, lock loss and reset.
module tb_sfo_top;
    localparam int N = 8;   // serial-clock periods per subframe

    logic clk = 1'b0;
    logic rst_n, sck, fsync, i2s_mode, sf_load;
    logic sf_cs, sf_usr, sf_vbit, sf_par_err, sf_code_err, sf_locked, sf_blk_start;
    logic [7:0] sck_per_sub;
    logic cs_out, usr_out, blk_out, verr_out, err_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Bench model state.
    int   m_idx;
    logic prev_c, prev_u, prev_verr, prev_err, prev_blk;

    always #5 clk = ~clk;

    sfo_top dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .fsync(fsync), .i2s_mode(i2s_mode),
        .sck_per_sub(sck_per_sub), .sf_load(sf_load), .sf_cs(sf_cs), .sf_usr(sf_usr),
        .sf_vbit(sf_vbit), .sf_par_err(sf_par_err), .sf_code_err(sf_code_err),
        .sf_locked(sf_locked), .sf_blk_start(sf_blk_start), .cs_out(cs_out),
        .usr_out(usr_out), .blk_out(blk_out), .verr_out(verr_out), .err_out(err_out)
    );

    // Vector: {cs,usr,v,par,code,lock,blk} then expected {c,u,verr,err}.
    localparam logic [10:0] VEC [12] = '{
        {7'b1000011, 4'b1000},
        {7'b0100010, 4'b0100},
        {7'b1110010, 4'b1110},
        {7'b0001010, 4'b0011},
        {7'b1000110, 4'b1011},
        {7'b0100000, 4'b0111},
        {7'b1000010, 4'b1000},
        {7'b0011110, 4'b0011},
        {7'b1100011, 4'b1100},
        {7'b0000010, 4'b0000},
        {7'b1010000, 4'b1011},
        {7'b0100010, 4'b0100}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sck = 1'b0; fsync = 1'b0; sf_load = 1'b0;
        {sf_cs, sf_usr, sf_vbit, sf_par_err, sf_code_err, sf_locked, sf_blk_start} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_idx = 0;
        {prev_c, prev_u, prev_verr, prev_err, prev_blk} = '0;
        // R10: all outputs zero after reset
        chk({cs_out, usr_out, blk_out, verr_out, err_out} == 5'b0, "R10 reset outputs",
            int'({cs_out, usr_out, blk_out, verr_out, err_out}), 0);
    endtask

    // Bench model of the block marker for one committed subframe.
    function automatic logic model_blk(input logic lock, input logic blk);
        logic m;
        if (!lock) begin
            m = 1'b0; m_idx = 0;
        end else if (blk) begin
            m = 1'b1; m_idx = 1;
        end else begin
            m = (m_idx < 64);
            m_idx = (m_idx == 383) ? 0 : m_idx + 1;
        end
        return m;
    endfunction

    // One subframe: frame-sync edge, flag load, then N-1 further periods.
    task automatic subframe(input logic [6:0] fl, input logic [3:0] ex, input bit full);
        logic nb;
        @(negedge clk); sck = 1'b1; fsync = 1'b1;
        @(negedge clk);
        // Previous subframe's results are visible right after the edge.
        chk(blk_out == prev_blk, "R7 blk marker", blk_out, prev_blk);
        if (full) begin
            chk(cs_out == prev_c, "R1 cs bit", cs_out, prev_c);
            chk(usr_out == prev_u, "R1 user bit", usr_out, prev_u);
            chk(err_out == prev_err, "R2 err flag", err_out, prev_err);
            chk(verr_out == prev_verr, "R3 verr flag", verr_out, prev_verr);
        end
        @(negedge clk); sck = 1'b0; fsync = 1'b0;
        @(negedge clk);
        sf_load = 1'b1;
        {sf_cs, sf_usr, sf_vbit, sf_par_err, sf_code_err, sf_locked, sf_blk_start} = fl;
        @(negedge clk); sf_load = 1'b0;
        nb = model_blk(fl[1], fl[0]);
        for (int p = 1; p < N; p++) begin
            @(negedge clk); sck = 1'b1;
            @(negedge clk);
            if (p == N - 1 && full) begin
                if (!i2s_mode) begin
                    chk(cs_out == ex[3], "R5 cs early", cs_out, ex[3]);
                    chk(blk_out == nb, "R5 blk early", blk_out, nb);
                end else begin
                    chk(cs_out == prev_c, "R6 cs held to edge", cs_out, prev_c);
                    chk(blk_out == prev_blk, "R6 blk held to edge", blk_out, prev_blk);
                end
                chk(err_out == prev_err, "R4 err held to edge", err_out, prev_err);
                chk(verr_out == prev_verr, "R4 verr held to edge", verr_out, prev_verr);
            end
            @(negedge clk); sck = 1'b0;
            @(negedge clk);
        end
        {prev_c, prev_u, prev_verr, prev_err} = ex;
        prev_blk = nb;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        sck_per_sub = 8'(N);
        i2s_mode = 1'b0;
        rst_n = 1'b0;
        // Table walk in both port formats.
        for (int mode = 0; mode < 2; mode++) begin
            i2s_mode = mode[0];
            do_reset();
            for (int k = 0; k < 12; k++)
                subframe(VEC[k][10:4], VEC[k][3:0], 1'b1);
            subframe(7'b0000010, 4'b0000, 1'b1);
        end

        // R7/R8: full block from a restart, marker high 64, low 320, wrap.
        i2s_mode = 1'b0;
        do_reset();
        subframe(7'b0000011, 4'b0000, 1'b0);
        for (int k = 0; k < 400; k++)
            subframe(7'b0000010, 4'b0000, 1'b0);

        // R8: restart in mid-block. R9: lock loss clears the marker and the index.
        for (int k = 0; k < 10; k++) subframe(7'b0000010, 4'b0000, 1'b0);
        subframe(7'b0000011, 4'b0000, 1'b0);
        for (int k = 0; k < 70; k++) subframe(7'b0000010, 4'b0000, 1'b0);
        subframe(7'b0000000, 4'b0011, 1'b0);
        for (int k = 0; k < 66; k++) subframe(7'b0000010, 4'b0000, 1'b0);
        subframe(7'b0000010, 4'b0000, 1'b1);

        // R10: reset in mid-stream clears everything.
        subframe(7'b1110010, 4'b1110, 1'b1);
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule